// File: doc/BRIEF.md
# USB Device Mode and Suspend Controller

This block holds the byte-wide mode register of a high-speed USB device controller and runs the timed sequences that its command bits start. A host processor writes the register over a simple parallel bus, which may be 8 or 16 bits wide. The register bits drive the clock-gate enable for the oscillator and PLL, the global interrupt enable and the pull-up connect enable. Three command bits start a soft reset, suspend entry and an upstream resume request. A command bit acts only when a write of 1 is followed by a write of 0. The block reads back its register value on a dedicated output.

The sequencer has five states. ACTIVE is the normal running state. RSM_WAIT is the pre-resume delay. RSM_DRIVE is the interval in which the upstream resume request is asserted. SUSP_RUN is suspended with the clock still enabled. SUSP_STOP is suspended with the clock gated.

The transitions are these:
- ACTIVE to RSM_WAIT on a resume trigger.
- ACTIVE to SUSP_RUN on a suspend trigger.
- RSM_WAIT to RSM_DRIVE when the 5 ms delay ends.
- RSM_DRIVE to ACTIVE when the 10 ms interval ends.
- SUSP_RUN to SUSP_STOP when 2 ms have elapsed and clock-always-on is 0.
- SUSP_STOP to SUSP_RUN when clock-always-on becomes 1.
- Either suspend state to RSM_WAIT on a resume trigger.
- Either suspend state to ACTIVE on a chip-select wake-up.
- Any state to ACTIVE on a USB bus reset or a soft reset.

Delays are counted in ticks of a one-cycle tick input. The parameter `TICKS_PER_MS` sets how many ticks make one millisecond.

Top module: `usbm_mode_ctrl`

## Requirements
- R1: The mode register sits at bus address 0x0C and is written from the low byte of the write data; a write to any other address leaves it unchanged. Bit map: 7 clock-always-on, 6 send-resume, 5 go-suspend, 4 soft-reset, 3 global-interrupt-enable, 2 wake-on-chip-select, 1 reserved, 0 pull-up connect. `mode_rd` shows the register value.
- R2: Bits 15:8 of the write data have no effect on the register.
- R3: Bit 1 ignores written data and always reads 0.
- R4: After hardware reset, the register reads 0x00, the state is ACTIVE, `clk_en` is 1 and all other outputs are 0.
- R5: A USB bus reset keeps bits 3 and 0, clears all other bits and returns the sequencer to ACTIVE, which aborts any pending resume.
- R6: Bits 6, 5 and 4 start their action only on a register write that changes them from 1 to 0. Writing a 1 alone has no effect on the outputs.
- R7: A send-resume trigger keeps `resume_req` at 0 for 5 ms worth of ticks. It then holds `resume_req` at 1 for 10 ms worth of ticks and then returns it to 0.
- R8: A go-suspend trigger sets `suspended` at once. With bit 7 at 0, `clk_en` drops on the 2 ms-th tick after the trigger.
- R9: While bit 7 is 1, `clk_en` stays 1 during suspend. If bit 7 is cleared after 2 ms have already passed, `clk_en` drops on the following cycle.
- R10: While the device is suspended and bit 2 is 1, a low `cs_n` gives a one-cycle `wakeup_req`. In that same cycle `suspended` goes to 0 and `clk_en` to 1. With bit 2 at 0, a low `cs_n` does nothing.
- R11: A soft-reset trigger gives a one-cycle `soft_rst_pulse`. On the next cycle the register reads 0x00 and the sequencer is back in ACTIVE.
- R12: `glint_en` follows bit 3 and `pullup_en` follows bit 0.
- R13: A resume trigger during suspend leaves suspend and re-enables the clock in the cycle of the trigger, then runs the R7 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| bus_reset | input | 1 | USB bus reset, one-cycle synchronous |
| tick | input | 1 | One-cycle timing tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; only bits 7:0 are used |
| cs_n | input | 1 | Chip select, active low |
| mode_rd | output | 8 | Mode register value |
| soft_rst_pulse | output | 1 | Soft-reset pulse |
| suspended | output | 1 | Device is in suspend |
| resume_req | output | 1 | Upstream resume request |
| clk_en | output | 1 | Oscillator and PLL enable |
| glint_en | output | 1 | Global interrupt enable |
| pullup_en | output | 1 | Pull-up connect enable |
| wakeup_req | output | 1 | Chip-select wake-up request |

## Verification
A wrong sequencer state shows directly at the ports. `suspended`, `clk_en` and `resume_req` are decoded from the state, so a bad transition is visible on the cycle after the edge that caused it. A tick counter that is off by one moves the `resume_req` or `clk_en` edge by one tick, and the bench catches this by sampling one tick before each expected edge and on the edge itself. A wrongly armed command bit shows up as an output change after a write of 1 alone, or as a missing change after the 1-to-0 write. A register bit lost on bus reset or soft reset shows on `mode_rd` one cycle later.

// File: rtl/usbm_pkg.sv
package usbm_pkg;

    localparam int REG_W       = 8;

    localparam int B_CLK_AON   = 7;
    localparam int B_RESUME    = 6;
    localparam int B_SUSPEND   = 5;
    localparam int B_SOFT_RST  = 4;
    localparam int B_INT_EN    = 3;
    localparam int B_WAKE_CS   = 2;
    localparam int B_RSVD      = 1;
    localparam int B_PULLUP    = 0;

    // Bits that survive a USB bus reset
    localparam logic [REG_W-1:0] BUSRST_KEEP = 8'h09;

    // Bits that can hold a value (the reserved bit is masked off)
    localparam logic [REG_W-1:0] WRITE_MASK  = 8'hFD;

    typedef enum logic [2:0] {
        ST_ACTIVE    = 3'd0,
        ST_RSM_WAIT  = 3'd1,
        ST_RSM_DRIVE = 3'd2,
        ST_SUSP_RUN  = 3'd3,
        ST_SUSP_STOP = 3'd4
    } mode_state_e;

endpackage

// File: rtl/usbm_regfile.sv
module usbm_regfile
    import usbm_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_byte,
    output logic [REG_W-1:0]  mode_q,
    output logic              trig_resume,
    output logic              trig_suspend,
    output logic              sr_pulse_q
);

    logic wr_hit;
    logic trig_soft;

    assign wr_hit       = wr_en && (wr_addr == MODE_ADDR) && !bus_reset && !sr_pulse_q;
    assign trig_resume  = wr_hit && mode_q[B_RESUME]   && !wr_byte[B_RESUME];
    assign trig_suspend = wr_hit && mode_q[B_SUSPEND]  && !wr_byte[B_SUSPEND];
    assign trig_soft    = wr_hit && mode_q[B_SOFT_RST] && !wr_byte[B_SOFT_RST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            sr_pulse_q <= 1'b0;
        end else if (sr_pulse_q) begin
            mode_q     <= '0;
            sr_pulse_q <= 1'b0;
        end else begin
            sr_pulse_q <= trig_soft;
            if (bus_reset) begin
                mode_q <= mode_q & BUSRST_KEEP;
            end else if (wr_hit) begin
                mode_q <= wr_byte & WRITE_MASK;
            end
        end
    end

    assert_addr_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != MODE_ADDR && !bus_reset && !sr_pulse_q) |=> $stable(mode_q));

    assert_busrst_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !sr_pulse_q) |=>
            (mode_q[B_INT_EN] == $past(mode_q[B_INT_EN])) &&
            (mode_q[B_PULLUP] == $past(mode_q[B_PULLUP])) &&
            (mode_q[7:4] == 4'h0) && (mode_q[2:1] == 2'b00));

    assert_softrst_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sr_pulse_q |=> (!sr_pulse_q && mode_q == '0));

endmodule

// File: rtl/usbm_timer.sv
module usbm_timer #(
    parameter int MAX_T = 80,
    parameter int CNT_W = $clog2(MAX_T + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/usbm_seq.sv
module usbm_seq
    import usbm_pkg::*;
#(
    parameter int WAIT_T = 40,
    parameter int DRV_T  = 80,
    parameter int STOP_T = 16,
    parameter int CNT_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             trig_resume,
    input  logic             trig_suspend,
    input  logic             clk_aon,
    input  logic             wake_cs_en,
    input  logic             cs_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    output logic             tmr_clr,
    output logic             suspended,
    output logic             resume_req,
    output logic             clk_en,
    output logic             wakeup_req
);

    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_T - 1);
    localparam logic [CNT_W-1:0] DRV_LAST  = CNT_W'(DRV_T - 1);
    localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_T - 1);
    localparam logic [CNT_W-1:0] STOP_FULL = CNT_W'(STOP_T);

    mode_state_e state_q, state_nxt;
    logic        in_susp;
    logic        wake_hit;
    logic        stop_due;

    assign in_susp  = (state_q == ST_SUSP_RUN) || (state_q == ST_SUSP_STOP);
    assign wake_hit = wake_cs_en && !cs_n;
    assign stop_due = (cnt >= STOP_FULL) || (tick && cnt == STOP_LAST);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (trig_resume)       state_nxt = ST_RSM_WAIT;
                else if (trig_suspend) state_nxt = ST_SUSP_RUN;
            end
            ST_RSM_WAIT: begin
                if (tick && cnt == WAIT_LAST) state_nxt = ST_RSM_DRIVE;
            end
            ST_RSM_DRIVE: begin
                if (tick && cnt == DRV_LAST) state_nxt = ST_ACTIVE;
            end
            ST_SUSP_RUN: begin
                if (trig_resume)               state_nxt = ST_RSM_WAIT;
                else if (wake_hit)             state_nxt = ST_ACTIVE;
                else if (!clk_aon && stop_due) state_nxt = ST_SUSP_STOP;
            end
            ST_SUSP_STOP: begin
                if (trig_resume)   state_nxt = ST_RSM_WAIT;
                else if (wake_hit) state_nxt = ST_ACTIVE;
                else if (clk_aon)  state_nxt = ST_SUSP_RUN;
            end
            default: state_nxt = ST_ACTIVE;
        endcase
        if (sync_clr) state_nxt = ST_ACTIVE;
    end

    assign tmr_clr = sync_clr || (state_nxt != state_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_ACTIVE;
            wakeup_req <= 1'b0;
        end else begin
            state_q    <= state_nxt;
            wakeup_req <= !sync_clr && in_susp && !trig_resume && wake_hit;
        end
    end

    // Outputs decoded from state
    always_comb begin
        suspended  = 1'b0;
        resume_req = 1'b0;
        clk_en     = 1'b1;
        unique case (state_q)
            ST_RSM_DRIVE: resume_req = 1'b1;
            ST_SUSP_RUN:  suspended  = 1'b1;
            ST_SUSP_STOP: begin
                suspended = 1'b1;
                clk_en    = 1'b0;
            end
            default: ;
        endcase
    end

    assert_drive_after_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_req) |-> ($past(state_q) == ST_RSM_WAIT));

    assert_clk_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> ($past(suspended) && !$past(clk_aon)));

    assert_aon_keeps_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && clk_aon) |=> clk_en);

    assert_wake_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup_req |-> (!suspended && clk_en));

endmodule

// File: rtl/usbm_mode_ctrl.sv
module usbm_mode_ctrl
    import usbm_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                DATA_W       = 16,
    parameter logic [ADDR_W-1:0] MODE_ADDR    = 8'h0C,
    parameter int                TICKS_PER_MS = 8,
    parameter int                RSM_DELAY_MS = 5,
    parameter int                RSM_LEN_MS   = 10,
    parameter int                CLK_STOP_MS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cs_n,
    output logic [REG_W-1:0]  mode_rd,
    output logic              soft_rst_pulse,
    output logic              suspended,
    output logic              resume_req,
    output logic              clk_en,
    output logic              glint_en,
    output logic              pullup_en,
    output logic              wakeup_req
);

    localparam int WAIT_T = RSM_DELAY_MS * TICKS_PER_MS;
    localparam int DRV_T  = RSM_LEN_MS   * TICKS_PER_MS;
    localparam int STOP_T = CLK_STOP_MS  * TICKS_PER_MS;
    localparam int MAX_A  = (WAIT_T > DRV_T) ? WAIT_T : DRV_T;
    localparam int MAX_T  = (MAX_A > STOP_T) ? MAX_A : STOP_T;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    logic [REG_W-1:0] mode_q;
    logic [REG_W-1:0] wr_byte;
    logic             trig_resume;
    logic             trig_suspend;
    logic             sr_pulse_q;
    logic             tmr_clr;
    logic [CNT_W-1:0] cnt;

    assign wr_byte = wr_data[REG_W-1:0];

    generate
        if (DATA_W > REG_W) begin : g_wide_bus
            logic unused_hi_byte;
            assign unused_hi_byte = ^wr_data[DATA_W-1:REG_W];
        end
    endgenerate

    usbm_regfile #(
        .ADDR_W    (ADDR_W),
        .MODE_ADDR (MODE_ADDR)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_reset    (bus_reset),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_byte      (wr_byte),
        .mode_q       (mode_q),
        .trig_resume  (trig_resume),
        .trig_suspend (trig_suspend),
        .sr_pulse_q   (sr_pulse_q)
    );

    usbm_timer #(
        .MAX_T (MAX_T),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick),
        .cnt   (cnt)
    );

    usbm_seq #(
        .WAIT_T (WAIT_T),
        .DRV_T  (DRV_T),
        .STOP_T (STOP_T),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_clr     (sr_pulse_q || bus_reset),
        .trig_resume  (trig_resume),
        .trig_suspend (trig_suspend),
        .clk_aon      (mode_q[B_CLK_AON]),
        .wake_cs_en   (mode_q[B_WAKE_CS]),
        .cs_n         (cs_n),
        .tick         (tick),
        .cnt          (cnt),
        .tmr_clr      (tmr_clr),
        .suspended    (suspended),
        .resume_req   (resume_req),
        .clk_en       (clk_en),
        .wakeup_req   (wakeup_req)
    );

    assign mode_rd        = mode_q;
    assign soft_rst_pulse = sr_pulse_q;
    assign glint_en       = mode_q[B_INT_EN];
    assign pullup_en      = mode_q[B_PULLUP];

endmodule

// File: tb/sim_usbm_mode_ctrl.sv
module sim_usbm_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TPM        = 2;
    localparam int WAIT_TK    = 5 * TPM;
    localparam int DRV_TK     = 10 * TPM;
    localparam int STOP_TK    = 2 * TPM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [15:0] wr_data = 16'h0000;
    logic        cs_n = 1'b1;
    logic [7:0]  mode_rd;
    logic        soft_rst_pulse, suspended, resume_req, clk_en;
    logic        glint_en, pullup_en, wakeup_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbm_mode_ctrl #(.TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cs_n(cs_n),
        .mode_rd(mode_rd), .soft_rst_pulse(soft_rst_pulse), .suspended(suspended),
        .resume_req(resume_req), .clk_en(clk_en), .glint_en(glint_en),
        .pullup_en(pullup_en), .wakeup_req(wakeup_req)
    );

    // {addr[31:24], data[23:8], expected readback[7:0]}
    localparam logic [31:0] VEC [9] = '{
        {8'h0C, 16'h0001, 8'h01},
        {8'h0C, 16'h0008, 8'h08},
        {8'h0C, 16'hFF89, 8'h89},
        {8'h0C, 16'h0002, 8'h00},
        {8'h0C, 16'h008F, 8'h8D},
        {8'h10, 16'h00FF, 8'h8D},
        {8'h0D, 16'h0000, 8'h8D},
        {8'h0C, 16'hA584, 8'h84},
        {8'h0C, 16'h0000, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R4 reset state
        chk("R4 mode_rd", mode_rd, 8'h00);
        chk("R4 clk_en", {7'd0, clk_en}, 8'h01);
        chk("R4 others", {2'b0, soft_rst_pulse, suspended, resume_req, glint_en, pullup_en, wakeup_req}, 8'h00);

        // R1 R2 R3 R12 vector walk
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][31:24], VEC[i][23:8]);
            chk("R1/R2/R3 readback", mode_rd, VEC[i][7:0]);
            chk("R12 enables", {6'd0, glint_en, pullup_en}, {6'd0, VEC[i][3], VEC[i][0]});
        end

        // R6 write of 1 alone, then R7 resume timing
        wr(8'h0C, 16'h0040);
        ticks(12);
        chk("R6 resume bit alone", {6'd0, resume_req, suspended}, 8'h00);
        wr(8'h0C, 16'h0000);
        ticks(WAIT_TK - 1);
        chk("R7 before delay end", {7'd0, resume_req}, 8'h00);
        ticks(1);
        chk("R7 resume asserted", {6'd0, resume_req, clk_en}, 8'h03);
        ticks(DRV_TK - 1);
        chk("R7 resume held", {7'd0, resume_req}, 8'h01);
        ticks(1);
        chk("R7 resume released", {7'd0, resume_req}, 8'h00);

        // R8 suspend and clock stop
        wr(8'h0C, 16'h0020);
        chk("R6 suspend bit alone", {7'd0, suspended}, 8'h00);
        wr(8'h0C, 16'h0000);
        chk("R8 suspended", {6'd0, suspended, clk_en}, 8'h03);
        ticks(STOP_TK - 1);
        chk("R8 clock before 2ms", {7'd0, clk_en}, 8'h01);
        ticks(1);
        chk("R8 clock stopped", {6'd0, suspended, clk_en}, 8'h02);

        // R13 resume from clock-stopped suspend
        wr(8'h0C, 16'h0040);
        chk("R6 no exit on 1", {6'd0, suspended, clk_en}, 8'h02);
        wr(8'h0C, 16'h0000);
        chk("R13 exit suspend", {6'd0, suspended, clk_en}, 8'h01);
        ticks(WAIT_TK);
        chk("R13 resume timing", {7'd0, resume_req}, 8'h01);
        ticks(DRV_TK);
        chk("R13 resume done", {7'd0, resume_req}, 8'h00);

        // R9 clock-always-on
        wr(8'h0C, 16'h00A0);
        wr(8'h0C, 16'h0080);
        ticks(10);
        chk("R9 clock kept", {6'd0, suspended, clk_en}, 8'h03);
        wr(8'h0C, 16'h0000);
        idle(1);
        chk("R9 clock stops after clear", {6'd0, suspended, clk_en}, 8'h02);

        // R10 wake on chip select
        cs_n = 1'b0;
        idle(2);
        chk("R10 no wake when disabled", {6'd0, suspended, wakeup_req}, 8'h02);
        cs_n = 1'b1;
        wr(8'h0C, 16'h0004);
        chk("R10 still suspended", {7'd0, suspended}, 8'h01);
        cs_n = 1'b0;
        idle(1);
        chk("R10 wake", {5'd0, wakeup_req, suspended, clk_en}, 8'h05);
        cs_n = 1'b1;
        idle(1);
        chk("R10 wake one cycle", {7'd0, wakeup_req}, 8'h00);

        // R5 bus reset aborts resume
        wr(8'h0C, 16'h00FF);
        chk("R3 reserved masked", mode_rd, 8'hFD);
        wr(8'h0C, 16'h00BF);
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        chk("R5 kept bits", mode_rd, 8'h09);
        chk("R12 after bus reset", {6'd0, glint_en, pullup_en}, 8'h03);
        ticks(WAIT_TK + 4);
        chk("R5 resume aborted", {7'd0, resume_req}, 8'h00);

        // R11 soft reset
        wr(8'h0C, 16'h0039);
        wr(8'h0C, 16'h0009);
        chk("R11 pulse", {6'd0, soft_rst_pulse, suspended}, 8'h03);
        chk("R11 reg during pulse", mode_rd, 8'h09);
        idle(1);
        chk("R11 pulse ends", {6'd0, soft_rst_pulse, suspended}, 8'h00);
        chk("R11 reg cleared", mode_rd, 8'h00);

        // R4 hardware reset mid-run
        wr(8'h0C, 16'h00AD);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R4 hw reset clears", mode_rd, 8'h00);

        finish_run();
    end

endmodule